// File: doc/BRIEF.md
# Fuse Blob Sequencer

This block takes a packed fuse description, the blob, as a stream of bytes with a valid/ready handshake and keeps it in a local byte buffer. Once the last byte has arrived, it reads the header, checks the blob as a whole, and then walks the table of fuse nodes. Each node names a fuse type and points at a value stored somewhere in the blob. For each node, the block sends one or more 32-bit burn commands to a downstream fuse programmer.

The value area is packed tightly, and the node table can sit anywhere in the blob, so every field is reached through a byte offset. Before any command leaves the block, a full validation pass checks every node. Burning then follows node order exactly, with no reordering. Each command is held until the programmer acknowledges it. A failure reported by the programmer ends the run and returns the index of the failing node.

Top module: `fuse_blob_sequencer`

## Requirements
- R1: After reset, `in_ready` is 1 and `burn_valid`, `done` and `error` are 0. A byte is taken on every clock where `in_valid` and `in_ready` are both high. The byte taken with `in_last` high ends loading, and `in_ready` is 0 from the next cycle onward.
- R2: The header holds five little-endian 32-bit words, at byte offsets 0, 4, 8, 12 and 16:
  - offset 0: magic;
  - offset 4: version, whose bytes 4 to 6 are ignored by the block;
  - offset 8: total blob size in bytes;
  - offset 12: node count;
  - offset 16: byte offset of the node table.
- R3: The magic must read 0x46555345, which means the stream bytes at offsets 0 to 3 are 45 53 55 46. Any other value ends the run with `err_code` 1 and issues no burn.
- R4: The run ends with `err_code` 2 and issues no burn in any of these cases:
  - the number of received bytes differs from the header size;
  - the header size is below 20;
  - the header size exceeds the buffer depth.
- R5: The run ends with `err_code` 3, with `err_node` set to the offending node index, and issues no burn at all in either of these cases:
  - the node table end (table offset + 12 × count) exceeds the blob size;
  - any node's value offset + value size exceeds the blob size.
  A value that ends exactly at the blob size is accepted.
- R6: Each node is 12 bytes, made of three little-endian words:
  - +0: type code;
  - +4: value size in bytes;
  - +8: value byte offset.
  Values can start at any byte address.
- R7: Burns are issued in node-table order, with no reordering. A node whose value size is 0 issues no burn.
- R8: Word w of a value carries value bytes 4w to 4w+3, with the lowest byte in bits 7:0. `burn_word` counts up from 0 within each node. In a trailing partial word, the bytes past the value size are 0.
- R9: `burn_valid` stays high with `burn_type`, `burn_word` and `burn_data` stable until `burn_ack` is sampled high. No next command is offered before that.
- R10: If a command is acknowledged with `burn_err` high, no further command is issued, `err_code` becomes 4 and `err_node` holds the index of that node.
- R11: After the last command is acknowledged, or at once for a blob with zero nodes, `done` rises and stays high with `error` low until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks the final blob byte |
| in_ready | output | 1 | Block accepts stream bytes |
| burn_valid | output | 1 | Burn command offered |
| burn_type | output | 32 | Fuse type code of the command |
| burn_word | output | WORD_W | Word index within the fuse value |
| burn_data | output | 32 | 32-bit value word to burn |
| burn_ack | input | 1 | Programmer has finished the command |
| burn_err | input | 1 | Programmer reports failure with the ack |
| done | output | 1 | All burns completed |
| error | output | 1 | Run aborted |
| err_code | output | 3 | 1 magic, 2 length, 3 range, 4 burn failure |
| err_node | output | IDX_W | Node index tied to a range or burn error |

## Verification
The bench goes after these corner cases:
- A value that ends exactly on the last blob byte. A design that used the wrong comparison there would reject a legal blob.
- An out-of-range last node. A single-pass design would burn the earlier fuses before noticing that node.
- A byte-reversed magic. A big-endian word read would accept it.
- Odd value sizes and a zero-size node. Wrong padding would show up in the upper data bytes, and a wrong zero-size rule would add a spurious command.
- A slow acknowledge. It exposes any command that changes or advances before its ack.
- A mid-run programmer failure. It must freeze the sequence and report node 2 rather than a word count.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

   localparam logic [31:0] BLOB_MAGIC  = 32'h4655_5345;
   localparam int unsigned HDR_BYTES  = 20;
   localparam int unsigned NODE_BYTES = 12;

   typedef enum logic [2:0] {
      ERR_NONE   = 3'd0,
      ERR_MAGIC  = 3'd1,
      ERR_LENGTH = 3'd2,
      ERR_RANGE  = 3'd3,
      ERR_BURN   = 3'd4
   } fbp_err_e;

   typedef enum logic [3:0] {
      ST_LOAD,
      ST_H_MAGIC,
      ST_H_SIZE,
      ST_H_COUNT,
      ST_H_FIRST,
      ST_C_SIZE,
      ST_C_OFF,
      ST_B_TYPE,
      ST_B_SIZE,
      ST_B_OFF,
      ST_B_FETCH,
      ST_B_ISSUE,
      ST_DONE,
      ST_FAIL
   } fbp_state_e;

endpackage

// File: rtl/fbp_buffer.sv
module fbp_buffer #(
   parameter int unsigned DEPTH = 256
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [7:0]  wr_byte,
   input  logic [31:0] rd_addr,
   output logic [31:0] rd_word,
   output logic [31:0] rx_count
);
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [31:0] DEPTH_W = 32'(DEPTH);

   logic [7:0]  mem [DEPTH];
   logic [31:0] cnt_q;

   // byte counter keeps counting past the depth so that an oversize blob is seen
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (wr_en && (cnt_q != '1)) begin
         cnt_q <= cnt_q + 32'd1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && (cnt_q < DEPTH_W)) begin
         mem[cnt_q[AW-1:0]] <= wr_byte;
      end
   end

   assign rx_count = cnt_q;

   // unaligned little-endian read: four byte lanes, each at its own address
   for (genvar b = 0; b < 4; b++) begin : g_lane
      logic [31:0] lane_addr;
      assign lane_addr = rd_addr + 32'(b);
      assign rd_word[8*b +: 8] = (lane_addr < DEPTH_W) ? mem[lane_addr[AW-1:0]] : 8'h00;
   end

   assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (cnt_q != '1)) |=> (cnt_q == $past(cnt_q) + 32'd1));

endmodule

// File: rtl/fbp_word_pad.sv
module fbp_word_pad (
   input  logic [31:0] raw_word,
   input  logic [31:0] bytes_left,
   output logic [31:0] padded_word
);
   // a lane passes only while the value still has a byte for it (R8)
   for (genvar b = 0; b < 4; b++) begin : g_pad
      assign padded_word[8*b +: 8] = (bytes_left > 32'(b)) ? raw_word[8*b +: 8] : 8'h00;
   end
endmodule

// File: rtl/fuse_blob_sequencer.sv
module fuse_blob_sequencer #(
   parameter int unsigned DEPTH  = 256,
   parameter int unsigned WORD_W = 8,
   parameter int unsigned IDX_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        in_data,
   input  logic              in_last,
   output logic              in_ready,
   output logic              burn_valid,
   output logic [31:0]       burn_type,
   output logic [WORD_W-1:0] burn_word,
   output logic [31:0]       burn_data,
   input  logic              burn_ack,
   input  logic              burn_err,
   output logic              done,
   output logic              error,
   output logic [2:0]        err_code,
   output logic [IDX_W-1:0]  err_node
);
   import fbp_pkg::*;

   localparam logic [31:0] DEPTH_W = 32'(DEPTH);
   localparam logic [31:0] HDR_W   = 32'(HDR_BYTES);
   localparam logic [35:0] NODE_W  = 36'(NODE_BYTES);

   initial begin
      if (DEPTH < HDR_BYTES)             $fatal(1, "DEPTH must hold the header");
      if (WORD_W < 1 || WORD_W > 32)     $fatal(1, "WORD_W out of range");
      if (IDX_W < 1 || IDX_W > 32)       $fatal(1, "IDX_W out of range");
   end

   fbp_state_e  state;
   fbp_err_e    code_q;
   logic [31:0] total_q, count_q, first_q, node_i;
   logic [31:0] t_type, t_size, t_off, w_idx, data_q;
   logic        nodes_ok;

   logic [31:0] rd_addr, rd_word, rx_count, padded, node_base, bytes_left;
   logic [35:0] tbl_end;
   logic [32:0] val_end;
   logic        more_words, last_node, take;

   assign take = in_valid && in_ready;

   fbp_buffer #(.DEPTH(DEPTH)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (take),
      .wr_byte  (in_data),
      .rd_addr  (rd_addr),
      .rd_word  (rd_word),
      .rx_count (rx_count)
   );

   assign bytes_left = t_size - {w_idx[29:0], 2'b00};

   fbp_word_pad u_pad (
      .raw_word    (rd_word),
      .bytes_left  (bytes_left),
      .padded_word (padded)
   );

   assign node_base  = first_q + node_i * 32'd12;
   assign tbl_end    = {4'b0, rd_word} + ({4'b0, count_q} * NODE_W);
   assign val_end    = {1'b0, rd_word} + {1'b0, t_size};
   assign more_words = ({w_idx, 2'b00} + 34'd4) < {2'b00, t_size};
   assign last_node  = (node_i + 32'd1) == count_q;

   always_comb begin
      unique case (state)
         ST_H_MAGIC: rd_addr = 32'd0;
         ST_H_SIZE:  rd_addr = 32'd8;
         ST_H_COUNT: rd_addr = 32'd12;
         ST_H_FIRST: rd_addr = 32'd16;
         ST_C_SIZE, ST_B_SIZE: rd_addr = node_base + 32'd4;
         ST_C_OFF,  ST_B_OFF:  rd_addr = node_base + 32'd8;
         ST_B_TYPE:  rd_addr = node_base;
         ST_B_FETCH: rd_addr = t_off + {w_idx[29:0], 2'b00};
         default:    rd_addr = 32'd0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_LOAD;
         code_q   <= ERR_NONE;
         total_q  <= '0;
         count_q  <= '0;
         first_q  <= '0;
         node_i   <= '0;
         t_type   <= '0;
         t_size   <= '0;
         t_off    <= '0;
         w_idx    <= '0;
         data_q   <= '0;
         nodes_ok <= 1'b0;
      end else begin
         unique case (state)
            ST_LOAD: if (take && in_last) state <= ST_H_MAGIC;
            ST_H_MAGIC: begin
               if (rd_word != BLOB_MAGIC) begin
                  state <= ST_FAIL; code_q <= ERR_MAGIC;
               end else begin
                  state <= ST_H_SIZE;
               end
            end
            ST_H_SIZE: begin
               total_q <= rd_word;
               if (rd_word != rx_count || rd_word < HDR_W || rd_word > DEPTH_W) begin
                  state <= ST_FAIL; code_q <= ERR_LENGTH;
               end else begin
                  state <= ST_H_COUNT;
               end
            end
            ST_H_COUNT: begin
               count_q <= rd_word;
               state   <= ST_H_FIRST;
            end
            ST_H_FIRST: begin
               first_q <= rd_word;
               node_i  <= '0;
               if (tbl_end > {4'b0, total_q}) begin
                  state <= ST_FAIL; code_q <= ERR_RANGE;
               end else if (count_q == '0) begin
                  nodes_ok <= 1'b1; state <= ST_DONE;
               end else begin
                  state <= ST_C_SIZE;
               end
            end
            ST_C_SIZE: begin
               t_size <= rd_word;
               state  <= ST_C_OFF;
            end
            ST_C_OFF: begin
               if (val_end > {1'b0, total_q}) begin
                  state <= ST_FAIL; code_q <= ERR_RANGE;
               end else if (last_node) begin
                  node_i <= '0; nodes_ok <= 1'b1; state <= ST_B_TYPE;
               end else begin
                  node_i <= node_i + 32'd1; state <= ST_C_SIZE;
               end
            end
            ST_B_TYPE: begin
               t_type <= rd_word;
               state  <= ST_B_SIZE;
            end
            ST_B_SIZE: begin
               t_size <= rd_word;
               state  <= ST_B_OFF;
            end
            ST_B_OFF: begin
               t_off <= rd_word;
               w_idx <= '0;
               if (t_size != '0) begin
                  state <= ST_B_FETCH;
               end else if (last_node) begin
                  state <= ST_DONE;
               end else begin
                  node_i <= node_i + 32'd1; state <= ST_B_TYPE;
               end
            end
            ST_B_FETCH: begin
               data_q <= padded;
               state  <= ST_B_ISSUE;
            end
            ST_B_ISSUE: begin
               if (burn_ack) begin
                  if (burn_err) begin
                     state <= ST_FAIL; code_q <= ERR_BURN;
                  end else if (more_words) begin
                     w_idx <= w_idx + 32'd1; state <= ST_B_FETCH;
                  end else if (last_node) begin
                     state <= ST_DONE;
                  end else begin
                     node_i <= node_i + 32'd1; state <= ST_B_TYPE;
                  end
               end
            end
            ST_DONE: state <= ST_DONE;
            default: state <= ST_FAIL;
         endcase
      end
   end

   assign in_ready   = (state == ST_LOAD);
   assign burn_valid = (state == ST_B_ISSUE);
   assign burn_type  = t_type;
   assign burn_word  = w_idx[WORD_W-1:0];
   assign burn_data  = data_q;
   assign done       = (state == ST_DONE);
   assign error      = (state == ST_FAIL);
   assign err_code   = code_q;
   assign err_node   = node_i[IDX_W-1:0];

   assert_load_closes_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_last) |=> !in_ready);

   assert_burn_after_checks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      burn_valid |-> nodes_ok);

   assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (burn_valid && !burn_ack) |=> (burn_valid && $stable(burn_type)
                                     && $stable(burn_word) && $stable(burn_data)));

   assert_burn_err_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (burn_valid && burn_ack && burn_err) |=> (error && !burn_valid && err_code == 3'd4));

   assert_done_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (done && !error && !burn_valid));

endmodule

// File: tb/sim_fuse_blob_sequencer.sv
module sim_fuse_blob_sequencer;
   localparam int CLK_PERIOD = 10;
   localparam int WORD_W = 8;
   localparam int IDX_W  = 8;
   localparam int NN     = 6;
   // node stimulus table: {type code, value size in bytes}
   localparam logic [31:0] VEC [NN][2] = '{
      '{32'h0000_0011, 32'd4},
      '{32'h0000_002A, 32'd16},
      '{32'h0000_0003, 32'd1},
      '{32'h0000_0104, 32'd7},
      '{32'h0000_0055, 32'd0},
      '{32'h0000_07F0, 32'd32}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic in_valid = 1'b0, in_last = 1'b0, in_ready;
   logic [7:0] in_data = 8'h00;
   logic burn_valid, burn_ack, burn_err, done, error;
   logic [31:0] burn_type, burn_data;
   logic [WORD_W-1:0] burn_word;
   logic [2:0] err_code;
   logic [IDX_W-1:0] err_node;

   always #(CLK_PERIOD/2) clk = ~clk;

   fuse_blob_sequencer u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_last(in_last), .in_ready(in_ready), .burn_valid(burn_valid),
      .burn_type(burn_type), .burn_word(burn_word), .burn_data(burn_data),
      .burn_ack(burn_ack), .burn_err(burn_err), .done(done), .error(error),
      .err_code(err_code), .err_node(err_node)
   );

   int nchk = 0, nfail = 0;
   logic [7:0]  blob [0:511];
   int          blen, tstart;
   logic [31:0] exp_type [0:63], exp_word [0:63], exp_data [0:63];
   logic [31:0] rec_type [0:63], rec_word [0:63], rec_data [0:63];
   int          nexp, nrec, hold_cnt, ack_delay, fail_at, hold_bad;
   logic [31:0] cap_t, cap_w, cap_d;

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int n, input int k);
      return 8'((n * 37 + k * 11 + 5) & 255);
   endfunction

   task automatic put32(input int a, input logic [31:0] v);
      blob[a] = v[7:0]; blob[a+1] = v[15:8]; blob[a+2] = v[23:16]; blob[a+3] = v[31:24];
   endtask

   // lay out a blob from the first nn table rows; vals_last puts the value area at the end
   task automatic build(input int nn, input bit vals_last);
      int vsum = 0, p, vstart;
      for (int n = 0; n < nn; n++) vsum += int'(VEC[n][1]);
      tstart = vals_last ? 20 : 20 + vsum;
      vstart = vals_last ? 20 + 12 * nn : 20;
      blen   = 20 + vsum + 12 * nn;
      put32(0, 32'h4655_5345);
      blob[4] = 8'd1; blob[5] = 8'd2; blob[6] = 8'd3; blob[7] = 8'd0;
      put32(8, 32'(blen)); put32(12, 32'(nn)); put32(16, 32'(tstart));
      p = vstart; nexp = 0;
      for (int n = 0; n < nn; n++) begin
         int s = int'(VEC[n][1]);
         for (int k = 0; k < s; k++) blob[p+k] = pat(n, k);
         put32(tstart + 12*n, VEC[n][0]);
         put32(tstart + 12*n + 4, VEC[n][1]);
         put32(tstart + 12*n + 8, 32'(p));
         p += s;
         for (int w = 0; w < (s + 3) / 4; w++) begin
            logic [31:0] d = '0;
            for (int b = 0; b < 4; b++)
               if (4*w + b < s) d[8*b +: 8] = pat(n, 4*w + b);
            exp_type[nexp] = VEC[n][0]; exp_word[nexp] = 32'(w); exp_data[nexp] = d;
            nexp++;
         end
      end
   endtask

   task automatic send();
      for (int i = 0; i < blen; i++) begin
         if (i % 4 == 3) begin @(negedge clk); in_valid = 1'b0; in_last = 1'b0; end
         @(negedge clk);
         in_valid = 1'b1; in_data = blob[i]; in_last = (i == blen - 1);
      end
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
   endtask

   task automatic wait_end();
      for (int c = 0; c < 4000 && !(done || error); c++) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic do_reset(input int dly, input int fat);
      @(negedge clk);
      rst_n = 1'b0; ack_delay = dly; fail_at = fat;
      repeat (3) @(negedge clk);
      nrec = 0; hold_bad = 0; hold_cnt = 0;
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic compare_burns();
      chk("R7", "burn count", 32'(nrec), 32'(nexp));
      for (int i = 0; i < nexp && i < nrec; i++) begin
         chk("R7", "burn type", rec_type[i], exp_type[i]);
         chk("R8", "burn word index", rec_word[i], exp_word[i]);
         chk("R8", "burn data", rec_data[i], exp_data[i]);
      end
      chk("R9", "command stable until ack", 32'(hold_bad), 32'd0);
   endtask

   // downstream programmer model
   initial begin
      burn_ack = 1'b0; burn_err = 1'b0;
      forever begin
         @(negedge clk);
         burn_ack = 1'b0; burn_err = 1'b0;
         if (rst_n && burn_valid) begin
            if (hold_cnt == 0) begin
               cap_t = burn_type; cap_w = 32'(burn_word); cap_d = burn_data;
            end
            if (hold_cnt < ack_delay) begin
               hold_cnt++;
            end else begin
               if (cap_t !== burn_type || cap_w !== 32'(burn_word) || cap_d !== burn_data) hold_bad++;
               rec_type[nrec] = burn_type; rec_word[nrec] = 32'(burn_word); rec_data[nrec] = burn_data;
               burn_ack = 1'b1;
               burn_err = (nrec == fail_at);
               nrec++;
               hold_cnt = 0;
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      ack_delay = 0; fail_at = -1; nrec = 0; hold_cnt = 0; hold_bad = 0;
      // reset state
      do_reset(0, -1);
      chk("R1", "in_ready after reset", 32'(in_ready), 32'd1);
      chk("R1", "burn_valid after reset", 32'(burn_valid), 32'd0);
      chk("R1", "done after reset", 32'(done), 32'd0);
      chk("R1", "error after reset", 32'(error), 32'd0);

      // full table, values before node table, immediate acks
      build(NN, 1'b0);
      send();
      chk("R1", "in_ready after last byte", 32'(in_ready), 32'd0);
      wait_end();
      chk("R11", "done", 32'(done), 32'd1);
      chk("R11", "error", 32'(error), 32'd0);
      chk("R2", "version bytes ignored", 32'(error), 32'd0);
      chk("R6", "unaligned values walked", 32'(nrec), 32'(nexp));
      compare_burns();

      // values at the end: last value ends exactly on blob size; slow acks
      do_reset(3, -1);
      build(NN, 1'b1);
      send();
      wait_end();
      chk("R5", "value ending at blob size accepted", 32'(done), 32'd1);
      compare_burns();

      // magic in the wrong byte order
      do_reset(0, -1);
      build(NN, 1'b0);
      blob[0] = 8'h46; blob[1] = 8'h55; blob[2] = 8'h53; blob[3] = 8'h45;
      send();
      wait_end();
      chk("R3", "magic error flag", 32'(error), 32'd1);
      chk("R3", "magic error code", 32'(err_code), 32'd1);
      chk("R3", "no burn on bad magic", 32'(nrec), 32'd0);

      // header size one more than bytes sent
      do_reset(0, -1);
      build(NN, 1'b0);
      put32(8, 32'(blen + 1));
      send();
      wait_end();
      chk("R4", "length error code", 32'(err_code), 32'd2);
      chk("R4", "no burn on length error", 32'(nrec), 32'd0);

      // last node's value overruns the blob by one byte
      do_reset(0, -1);
      build(NN, 1'b0);
      put32(tstart + 12*5 + 8, 32'(blen - 31));
      send();
      wait_end();
      chk("R5", "range error code", 32'(err_code), 32'd3);
      chk("R5", "range error node", 32'(err_node), 32'd5);
      chk("R5", "no burn before range error", 32'(nrec), 32'd0);

      // programmer fails the sixth command (node 2)
      do_reset(1, 5);
      build(NN, 1'b0);
      send();
      wait_end();
      chk("R10", "burn error code", 32'(err_code), 32'd4);
      chk("R10", "burn error node", 32'(err_node), 32'd2);
      chk("R10", "no burn after failure", 32'(nrec), 32'd6);
      chk("R10", "burn_valid low after failure", 32'(burn_valid), 32'd0);

      // zero nodes
      do_reset(0, -1);
      build(0, 1'b0);
      send();
      wait_end();
      chk("R11", "done on empty table", 32'(done), 32'd1);
      chk("R7", "no burn on empty table", 32'(nrec), 32'd0);

      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule